// File: doc/BRIEF.md
# Serial (7,4) Cyclic Code Encoder and Syndrome Checker

The block handles a (7,4) binary cyclic code with generator g(x) = x^3 + x + 1, one bit per clock. A word is opened by a one-cycle `start` pulse that also selects the operation. Seven bits then follow on `in_bit`, each qualified by `in_valid`, and the highest-order coefficient comes first. For each accepted bit the block returns one bit on `out_bit` with `out_valid` one cycle later.

One three-stage shift register with XOR feedback does all three jobs. In the non-systematic encode mode it multiplies the data polynomial by g(x), so the data does not show in the codeword. In the systematic encode mode it passes the four data bits through and divides x^3·d(x) by g(x), then shifts the three-bit remainder out behind them. In the check mode it divides the received 7-bit polynomial by g(x). The remainder left in the stages is the syndrome, which goes to a parallel output together with a one-cycle `done` strobe and an error flag that is set when the syndrome is nonzero. The block does not correct errors.

Top module: `cyc_code_serial`

## Requirements
- R1: After reset `out_valid`, `out_bit`, `done` and `word_err` are 0 and `syndrome` is 3'b000.
- R2: With `mode` = 2'b00 (non-systematic), the data bits d3..d0 are the first four bits accepted. The seven output bits are the coefficients c6..c0 of d(x)·g(x), highest first. Data 1111 gives 1101001.
- R3: With `mode` = 2'b01 (systematic), the first four output bits repeat d3..d0 unchanged. The last three are the remainder of x^3·d(x) divided by g(x), coefficient of x^2 first.
- R4: In both encode modes the values of the 5th to 7th accepted bits have no effect on the output.
- R5: With `mode` = 2'b10 or 2'b11 (check), each output bit echoes the accepted input bit. `done` is high for exactly the cycle after the 7th accepted bit. In that cycle `syndrome` holds r(x) mod g(x) (bit 2 = coefficient of x^2), and `word_err` is 1 exactly when the syndrome is nonzero.
- R6: Every valid codeword gives syndrome 0. Every single-bit error gives a nonzero syndrome, and no two error positions give the same syndrome. Every error in two adjacent bits gives a nonzero syndrome.
- R7: `out_valid` is high in exactly the cycles that follow an accepted bit.
- R8: `start` empties the shift stages and the bit count, so a word cut off partway and then restarted gives the same output as a clean word.
- R9: Once a word has received its 7 bits, and before the first `start`, `in_valid` is ignored: no `out_valid`, no `done`, and `syndrome` stays as it was.
- R10: A bit presented in the same cycle as `start` is not accepted.
- R11: `syndrome` and `word_err` keep their value until the next `start`, which clears both to 0. Only the end of a check-mode word loads them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that opens a word and clears the stages |
| mode | input | 2 | Operation taken at `start`: 00 non-systematic, 01 systematic, 1x check |
| in_valid | input | 1 | Qualifies `in_bit` |
| in_bit | input | 1 | Serial input, highest-order coefficient first |
| out_valid | output | 1 | Qualifies `out_bit` |
| out_bit | output | 1 | Serial output, highest-order coefficient first |
| done | output | 1 | One-cycle strobe after the 7th bit of a word |
| syndrome | output | 3 | Remainder of the last checked word |
| word_err | output | 1 | Last checked word had a nonzero syndrome |

## Verification
The bench goes after the switch from data to parity in systematic mode: a design that feeds the three filler bits into the feedback gives wrong parity whenever the filler is nonzero. It also targets the multiply taps on all sixteen data words, since one misplaced tap corrupts some codewords while leaving 1111 correct. Single-bit and adjacent double-bit errors at every position are checked against the computed remainders, so a wrong feedback tap shows up as syndromes that are wrong or that repeat. Restarting in the middle of a word, sending extra bits after the 7th, and asserting `start` together with a bit expose a design that keeps stale stage contents or miscounts bits.

// File: rtl/cyc_pkg.sv
// Shared types for the serial cyclic code unit.
package cyc_pkg;
    // Operation selected for one word.
    typedef enum logic [1:0] {
        MODE_MUL = 2'b00,  // non-systematic: multiply by g(x)
        MODE_SYS = 2'b01,  // systematic: data then remainder
        MODE_CHK = 2'b10   // syndrome computation
    } cyc_mode_e;
endpackage

// File: rtl/cyc_word_counter.sv
// Counts the accepted bits of one word.
// Assumes: start and accept are never high together (the top guarantees this).
// active is high from start until the last bit of the word has been accepted.
module cyc_word_counter #(
    parameter int N  = 7,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          accept,
    output logic [IW-1:0] idx,
    output logic          active,
    output logic          last
);
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    assign last = accept && (idx == LAST_IDX);

    // Bit index and word-open flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            active <= 1'b0;
        end else if (start) begin
            idx    <= '0;
            active <= 1'b1;
        end else if (last) begin
            idx    <= '0;
            active <= 1'b0;
        end else if (accept) begin
            idx    <= idx + 1'b1;
        end
    end

    // R8: the index never goes past the last position of a word
    a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);

    // R9: once the last bit has been accepted the word closes
    a_r9_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !active);
endmodule

// File: rtl/cyc_shift_core.sv
// Shift stages with XOR feedback, shared by the three operations.
// Generator GEN is given as R+1 coefficients, GEN[R] and GEN[0] both 1.
// MUL: the stages act as a delay line of the input; the output is the
//      tapped sum, which gives the coefficients of d(x)*g(x), highest first.
// SYS: data phase divides x^R*d(x) by g(x); parity phase shifts the remainder out.
// CHK: divides the received polynomial by g(x); the stages end with the remainder.
// Assumes: R >= 2, and the caller holds din at 0 after the data bits in MUL mode.
module cyc_shift_core
    import cyc_pkg::*;
#(
    parameter int         R   = 3,
    parameter logic [R:0] GEN = 4'b1011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  cyc_mode_e    mode,
    input  logic         parity_phase,
    input  logic         din,
    output logic         dout,
    output logic [R-1:0] stages,
    output logic [R-1:0] stages_nxt
);
    logic [R-1:0] st;
    logic         fb;

    assign stages = st;

    // Next stage contents and output bit for the selected operation.
    always_comb begin
        stages_nxt = st;
        dout       = 1'b0;
        fb         = 1'b0;
        case (mode)
            MODE_MUL: begin
                stages_nxt = {st[R-2:0], din};
                dout       = din & GEN[R];
                for (int j = 0; j < R; j++) begin
                    dout = dout ^ (GEN[j] & st[R-1-j]);
                end
            end
            MODE_SYS: begin
                if (!parity_phase) begin
                    fb            = din ^ st[R-1];
                    stages_nxt[0] = GEN[0] & fb;
                    for (int i = 1; i < R; i++) begin
                        stages_nxt[i] = st[i-1] ^ (GEN[i] & fb);
                    end
                    dout = din;
                end else begin
                    stages_nxt = {st[R-2:0], 1'b0};
                    dout       = st[R-1];
                end
            end
            default: begin
                fb            = st[R-1];
                stages_nxt[0] = din ^ (GEN[0] & fb);
                for (int i = 1; i < R; i++) begin
                    stages_nxt[i] = st[i-1] ^ (GEN[i] & fb);
                end
                dout = din;
            end
        endcase
    end

    // Stage register: cleared at the start of a word, advanced per accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (clear) begin
            st <= '0;
        end else if (shift_en) begin
            st <= stages_nxt;
        end
    end

    // R8: a start leaves all stages empty
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (stages == '0));

    // R8: the stages only change when a bit is shifted or a word starts
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !shift_en) |=> $stable(stages));
endmodule

// File: rtl/cyc_code_serial.sv
// Bit-serial (7,4) cyclic code encoder / syndrome checker, g(x) = x^3 + x + 1.
// A start pulse takes the mode and opens a word of N accepted bits, highest
// coefficient first. Each accepted bit produces one registered output bit.
// After the last bit, done pulses; in check mode the syndrome and error flag
// are loaded at that point and held until the next start.
// Assumes: mode is only sampled at start; mode 2'b11 behaves as check.
module cyc_code_serial
    import cyc_pkg::*;
#(
    parameter int             N   = 7,
    parameter int             K   = 4,
    parameter logic [N-K:0]   GEN = 4'b1011,
    localparam int            R   = N - K,
    localparam int            IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   mode,
    input  logic         in_valid,
    input  logic         in_bit,
    output logic         out_valid,
    output logic         out_bit,
    output logic         done,
    output logic [R-1:0] syndrome,
    output logic         word_err
);
    cyc_mode_e    mode_q;
    logic [IW-1:0] idx;
    logic          active;
    logic          last;
    logic          accept;
    logic          parity_phase;
    logic          din_eff;
    logic          dout;
    logic [R-1:0]  stages;
    logic [R-1:0]  stages_nxt;

    assign accept       = in_valid && active && !start;
    assign parity_phase = (idx >= IW'(K));
    // Filler bits after the data are forced to zero in the encode modes.
    assign din_eff      = (mode_q != MODE_CHK && parity_phase) ? 1'b0 : in_bit;

    cyc_word_counter #(.N(N)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .idx    (idx),
        .active (active),
        .last   (last)
    );

    cyc_shift_core #(.R(R), .GEN(GEN)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (start),
        .shift_en     (accept),
        .mode         (mode_q),
        .parity_phase (parity_phase),
        .din          (din_eff),
        .dout         (dout),
        .stages       (stages),
        .stages_nxt   (stages_nxt)
    );

    // Mode taken at start; the unused code is treated as check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_MUL;
        end else if (start) begin
            case (mode)
                2'b00:   mode_q <= MODE_MUL;
                2'b01:   mode_q <= MODE_SYS;
                default: mode_q <= MODE_CHK;
            endcase
        end
    end

    // Registered serial output and end-of-word strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            done      <= 1'b0;
        end else begin
            out_valid <= accept;
            out_bit   <= accept ? dout : 1'b0;
            done      <= last;
        end
    end

    // Syndrome and error flag: cleared by start, loaded at the end of a check word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syndrome <= '0;
            word_err <= 1'b0;
        end else if (start) begin
            syndrome <= '0;
            word_err <= 1'b0;
        end else if (last && mode_q == MODE_CHK) begin
            syndrome <= stages_nxt;
            word_err <= |stages_nxt;
        end
    end

    // R7: an accepted bit produces an output bit in the next cycle
    a_r7_out_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R7: no output bit without an accepted input bit
    a_r7_no_spurious_out: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !out_valid);

    // R2: multiplication drains the stages back to zero at the end of a word
    a_r2_mul_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MODE_MUL) |-> (stages == '0));

    // R3: all remainder bits have been shifted out at the end of a word
    a_r3_sys_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MODE_SYS) |-> (stages == '0));

    // R5: in check mode the stages hold the reported syndrome when done pulses
    a_r5_syn_in_stages: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MODE_CHK) |-> (syndrome == stages));

    // R5: done is a single-cycle strobe
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: the syndrome only moves at a start or the end of a word
    a_r11_syn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !last) |=> ($stable(syndrome) && $stable(word_err)));
endmodule

// File: tb/test_cyc_code_serial.sv
// Directed bench for the serial cyclic code unit.
module test_cyc_code_serial;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [1:0] mode;
    logic       in_valid;
    logic       in_bit;
    logic       out_valid;
    logic       out_bit;
    logic       done;
    logic [2:0] syndrome;
    logic       word_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cyc_code_serial i_cyc_code_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .done      (done),
        .syndrome  (syndrome),
        .word_err  (word_err)
    );

    // Reference: product of a 4-bit data polynomial with g(x) = x^3 + x + 1.
    function automatic logic [6:0] ref_mul(input logic [3:0] d);
        logic [6:0] c = '0;
        for (int j = 0; j < 4; j++) if (d[j]) c = c ^ (7'b0001011 << j);
        return c;
    endfunction

    // Reference: remainder of a 7-bit polynomial divided by g(x).
    function automatic logic [2:0] ref_rem(input logic [6:0] v);
        logic [6:0] t = v;
        for (int i = 6; i >= 3; i--) if (t[i]) t = t ^ (7'b0001011 << (i - 3));
        return t[2:0];
    endfunction

    function automatic logic [6:0] ref_sys(input logic [3:0] d);
        return {d, ref_rem({d, 3'b000})};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one word: start (optionally with a bit on in_valid), then 7 bits.
    task automatic run_word(input logic [1:0] m, input logic [6:0] w, input bit collide,
                            output logic [6:0] got, output bit all_valid,
                            output logic [2:0] syn, output logic err, output logic dn);
        all_valid = 1;
        @(negedge clk);
        start = 1; mode = m; in_valid = collide; in_bit = collide;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < 7; i++) begin
            in_valid = 1; in_bit = w[6 - i];
            @(negedge clk);
            got[6 - i] = out_bit;
            if (!out_valid) all_valid = 0;
            if (i == 6) begin
                syn = syndrome; err = word_err; dn = done;
            end
        end
        in_valid = 0; in_bit = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; start = 0; mode = 0; in_valid = 0; in_bit = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(out_valid == 0 && out_bit == 0, "R1", "out after reset", {out_valid, out_bit}, 0);
        check(done == 0 && word_err == 0, "R1", "flags after reset", {done, word_err}, 0);
        check(syndrome == 3'b000, "R1", "syndrome after reset", syndrome, 0);
        // R9: bits before any start are ignored
        in_valid = 1; in_bit = 1;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 0 && done == 0, "R9", "bit before start", {out_valid, done}, 0);
        end
        in_valid = 0; in_bit = 0;
    endtask

    task automatic t_nonsys();
        logic [6:0] got; bit v; logic [2:0] s; logic e, dn;
        run_word(2'b00, 7'b1111000, 0, got, v, s, e, dn);
        check(got == 7'b1101001, "R2", "1111 non-systematic", got, 7'b1101001);
        for (int d = 0; d < 16; d++) begin
            run_word(2'b00, {4'(d), 3'b000}, 0, got, v, s, e, dn);
            check(got == ref_mul(4'(d)), "R2", $sformatf("mul data %0d", d), got, ref_mul(4'(d)));
            check(v && dn, "R7", "valid/done mul", {v, dn}, 3);
        end
    endtask

    task automatic t_sys();
        logic [6:0] got; bit v; logic [2:0] s; logic e, dn;
        for (int d = 0; d < 16; d++) begin
            run_word(2'b01, {4'(d), 3'b000}, 0, got, v, s, e, dn);
            check(got == ref_sys(4'(d)), "R3", $sformatf("sys data %0d", d), got, ref_sys(4'(d)));
        end
    endtask

    task automatic t_filler();
        logic [6:0] got; bit v; logic [2:0] s; logic e, dn;
        for (int d = 0; d < 16; d += 5) begin
            run_word(2'b00, {4'(d), 3'b111}, 0, got, v, s, e, dn);
            check(got == ref_mul(4'(d)), "R4", "mul filler ones", got, ref_mul(4'(d)));
            run_word(2'b01, {4'(d), 3'b101}, 0, got, v, s, e, dn);
            check(got == ref_sys(4'(d)), "R4", "sys filler ones", got, ref_sys(4'(d)));
        end
    endtask

    task automatic t_check_valid();
        logic [6:0] got; bit v; logic [2:0] s; logic e, dn;
        for (int d = 0; d < 16; d++) begin
            run_word(2'b10, ref_sys(4'(d)), 0, got, v, s, e, dn);
            check(s == 0 && e == 0 && dn, "R6", "sys codeword syndrome", {dn, e, s}, 8);
            check(got == ref_sys(4'(d)), "R5", "check echo", got, ref_sys(4'(d)));
            run_word(2'b11, ref_mul(4'(d)), 0, got, v, s, e, dn);
            check(s == 0 && e == 0, "R6", "mul codeword syndrome, mode 11", {e, s}, 0);
        end
    endtask

    task automatic t_errors();
        logic [6:0] got; bit v; logic [2:0] s; logic e, dn;
        logic [6:0] base = ref_sys(4'b1010);
        logic [7:0] seen = '0;
        for (int p = 0; p < 7; p++) begin
            logic [6:0] w = base ^ (7'b1 << p);
            run_word(2'b10, w, 0, got, v, s, e, dn);
            check(s == ref_rem(w) && e == 1, "R5", $sformatf("single error pos %0d", p),
                  {e, s}, {1'b1, ref_rem(w)});
            check(s != 0 && !seen[s], "R6", "single error distinct", s, ref_rem(w));
            seen[s] = 1;
        end
        for (int p = 0; p < 6; p++) begin
            logic [6:0] w = base ^ (7'b11 << p);
            run_word(2'b10, w, 0, got, v, s, e, dn);
            check(s == ref_rem(w) && s != 0 && e, "R6", $sformatf("adjacent pair %0d", p),
                  {e, s}, {1'b1, ref_rem(w)});
        end
    endtask

    task automatic t_restart();
        logic [6:0] got; bit v; logic [2:0] s; logic e, dn;
        @(negedge clk);
        start = 1; mode = 2'b01;
        @(negedge clk);
        start = 0; in_valid = 1; in_bit = 1;
        repeat (3) @(negedge clk);
        in_valid = 0;
        run_word(2'b01, {4'b0110, 3'b000}, 0, got, v, s, e, dn);
        check(got == ref_sys(4'b0110), "R8", "restart after partial", got, ref_sys(4'b0110));
        @(negedge clk);
        start = 1; mode = 2'b10;
        @(negedge clk);
        start = 0; in_valid = 1; in_bit = 1;
        repeat (4) @(negedge clk);
        in_valid = 0;
        run_word(2'b10, ref_sys(4'b0011), 0, got, v, s, e, dn);
        check(s == 0 && e == 0, "R8", "check restart", {e, s}, 0);
    endtask

    task automatic t_collide();
        logic [6:0] got; bit v; logic [2:0] s; logic e, dn;
        run_word(2'b00, {4'b0101, 3'b000}, 1, got, v, s, e, dn);
        check(got == ref_mul(4'b0101), "R10", "bit with start dropped", got, ref_mul(4'b0101));
        check(v && dn, "R10", "word length with collide", {v, dn}, 3);
    endtask

    task automatic t_extra_and_hold();
        logic [6:0] got; bit v; logic [2:0] s; logic e, dn;
        logic [6:0] w = ref_sys(4'b1100) ^ 7'b0010000;
        run_word(2'b10, w, 0, got, v, s, e, dn);
        in_valid = 1; in_bit = 1;
        repeat (4) begin
            @(negedge clk);
            check(out_valid == 0 && done == 0, "R9", "bit after word", {out_valid, done}, 0);
            check(syndrome == ref_rem(w) && word_err, "R9", "syndrome after extra bits",
                  syndrome, ref_rem(w));
        end
        in_valid = 0; in_bit = 0;
        repeat (3) @(negedge clk);
        check(syndrome == ref_rem(w) && word_err, "R11", "syndrome held idle", syndrome, ref_rem(w));
        run_word(2'b00, {4'b1001, 3'b000}, 0, got, v, s, e, dn);
        check(s == 0 && e == 0, "R11", "encode word after start", {e, s}, 0);
        run_word(2'b10, w, 0, got, v, s, e, dn);
        @(negedge clk);
        start = 1; mode = 2'b10;
        @(negedge clk);
        start = 0;
        check(syndrome == 0 && word_err == 0, "R11", "start clears syndrome", {word_err, syndrome}, 0);
        check(out_valid == 0, "R7", "no output after start", out_valid, 0);
    endtask

    initial begin
        t_reset();
        t_nonsys();
        t_sys();
        t_filler();
        t_check_valid();
        t_errors();
        t_restart();
        t_collide();
        t_extra_and_hold();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule